// File: doc/BRIEF.md
# Queued Completion Tracker with Interrupt Coalescing

This host-side block keeps account of up to 32 disk commands that are in flight at the same time. Each command is named by a 5-bit tag. When the host hands a command to the device, the block records the tag as outstanding. The device reports finished work with status packets. Each packet carries a 32-bit completion mask, and one packet may retire any number of tags at once. Packets may follow one another on consecutive cycles, and the host never has to answer a packet before the next one is taken.

A retired tag moves from the outstanding vector to the done vector on the clock edge that accepts the packet. It stays in the done vector until software acknowledges it by writing a 1 in that bit position. The block drives one level-sensitive interrupt line. The line is high while interrupts are enabled and at least one done bit is set. Completions that arrive while the line is already high are therefore merged into the pending interrupt, and a whole packet produces at most one interrupt.

Two kinds of protocol misuse set a sticky error flag:
- a completion bit for a tag that is not outstanding;
- the issue of a tag that is already outstanding.

The flag is cleared only by reset.

Top module: `cq_tracker_top`

## Requirements
- R1: After reset, the outstanding vector, the done vector and the error flag are all zero, and the interrupt is low.
- R2: An issue of a tag that is not outstanding sets that tag's outstanding bit on the next clock edge. Tag value t maps to bit t of the outstanding vector.
- R3: An issue of a tag that is already outstanding is rejected. The outstanding vector is not changed by that issue, and the error flag is set on the next edge.
- R4: On an accepted packet, every mask bit i whose tag is outstanding does two things at the same edge: it clears outstanding bit i and sets done bit i. Mask bit i refers to tag i, and several tags may retire in one packet.
- R5: Packets on consecutive cycles are all accepted, with no cycle of handshake or gap required between them.
- R6: A mask bit for a tag that is not outstanding is ignored: it leaves the done and outstanding vectors unchanged, and it sets the error flag on the next edge.
- R7: Once set, the error flag stays set until reset.
- R8: An acknowledge clears each done bit at whose position the acknowledge mask holds a 1. Done bits at positions holding 0 keep their value.
- R9: When an acknowledge and an accepted completion hit the same tag in the same cycle, the done bit ends set.
- R10: The interrupt is high exactly when the enable input is high and at least one done bit is set. Its value follows the registered done vector with no further delay.
- R11: While the interrupt is high, new completions do not make it fall. It stays high until acknowledges clear every done bit or the enable drops.
- R12: Issue and completion in the same cycle are both judged against the outstanding vector as it stood before that edge. A completion for a tag that is issued in that same cycle is therefore a stray (R6), and the issue still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_vld | input | 1 | A command is being issued this cycle |
| issue_tag | input | 5 | Tag of the issued command |
| pkt_vld | input | 1 | A status packet is present this cycle |
| pkt_mask | input | 32 | Completion mask of the packet, bit i = tag i |
| ack_vld | input | 1 | Software acknowledge is present this cycle |
| ack_mask | input | 32 | Write-one-to-clear mask for the done vector |
| irq_en | input | 1 | Interrupt enable |
| pend_vec | output | 32 | Outstanding tags |
| done_vec | output | 32 | Completed tags not yet acknowledged |
| proto_err | output | 1 | Sticky protocol error flag |
| irq | output | 1 | Level-sensitive host interrupt |

## Verification
Every input event becomes visible on the outstanding vector, the done vector and the error flag one clock edge after the cycle in which it is driven. The interrupt is combinational from the done register and the enable input, so it also changes one edge after the completion or acknowledge that causes it.

The bench drives its inputs on the falling edge and pushes the expected state for that cycle into a queue. A monitor pops one entry a short delay after each following rising edge and compares it against all four outputs, so each result is checked in exactly the cycle it is due. Multi-tag packets, back-to-back packets, set/clear collisions and same-cycle issue/completion collisions are all checked in this way.

// File: rtl/cq_pkg.sv
// Package: shared types of the queued completion tracker.
// Assumes: included in compile order before every tracker module.
package cq_pkg;

    // Tag count the tracker is normally built for.
    localparam int unsigned CQ_DEF_TAGS = 32;

    // Protocol faults detected in one cycle.
    typedef struct packed {
        logic dup_issue;   // issue of a tag that is already outstanding
        logic stray_done;  // completion bit for a tag not outstanding
    } cq_fault_t;

endpackage

// File: rtl/cq_outstanding.sv
// Module: cq_outstanding
// Keeps one outstanding bit per tag. An issue sets the bit unless the tag
// is already outstanding, in which case the issue is flagged as a duplicate.
// Assumes: retire_vec only holds bits that are currently outstanding.
module cq_outstanding #(
    parameter int unsigned TAGS  = 32,
    parameter int unsigned TAG_W = $clog2(TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [TAG_W-1:0] issue_tag,
    input  logic [TAGS-1:0]  retire_vec,
    output logic [TAGS-1:0]  pend_q,
    output logic             dup_issue
);

    logic [TAGS-1:0] issue_hit;

    // Duplicate issue: the addressed tag is already in flight.
    always_comb dup_issue = issue_vld && pend_q[issue_tag];

    for (genvar g = 0; g < TAGS; g++) begin : g_tag
        // Decode the issue onto this tag, accepted only if the tag is free.
        always_comb issue_hit[g] = issue_vld && (issue_tag == TAG_W'(g)) && !pend_q[g];

        // Per-tag outstanding flop: retire clears, accepted issue sets.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (retire_vec[g])
                pend_q[g] <= 1'b0;
            else if (issue_hit[g])
                pend_q[g] <= 1'b1;
        end
    end

    // R2: an accepted issue leaves its tag outstanding after the edge.
    a_r2_issue_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !pend_q[issue_tag]) |=> pend_q[$past(issue_tag)]);

    // R4: retired tags are no longer outstanding after the edge.
    a_r4_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|retire_vec) |=> ((pend_q & $past(retire_vec)) == '0));

    // R3: a duplicate issue does not change the outstanding set.
    a_r3_dup_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (dup_issue && retire_vec == '0) |=> $stable(pend_q));

endmodule

// File: rtl/cq_done_collector.sv
// Module: cq_done_collector
// Filters status packets against the outstanding set and keeps the done
// vector. Software clears done bits with write-one-to-clear acknowledges.
// A new completion wins over a clear of the same bit in the same cycle.
// Assumes: pend_q is the registered outstanding vector from this cycle.
module cq_done_collector #(
    parameter int unsigned TAGS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pkt_vld,
    input  logic [TAGS-1:0] pkt_mask,
    input  logic [TAGS-1:0] pend_q,
    input  logic            ack_vld,
    input  logic [TAGS-1:0] ack_mask,
    output logic [TAGS-1:0] retire_vec,
    output logic            stray_any,
    output logic [TAGS-1:0] done_q
);

    logic [TAGS-1:0] clr_vec;
    logic [TAGS-1:0] done_nxt;

    // Accepted completions are the mask bits whose tags are in flight.
    always_comb retire_vec = pkt_vld ? (pkt_mask & pend_q) : '0;

    // Any mask bit for a tag not in flight is a stray.
    always_comb stray_any = pkt_vld && ((pkt_mask & ~pend_q) != '0);

    // Clear request from software for this cycle.
    always_comb clr_vec = ack_vld ? ack_mask : '0;

    // Next done value: clear first, then set, so set wins.
    always_comb done_nxt = (done_q & ~clr_vec) | retire_vec;

    // Done register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= '0;
        else
            done_q <= done_nxt;
    end

    // R9: every accepted completion is present in done after the edge.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|retire_vec) |=> ((done_q & $past(retire_vec)) == $past(retire_vec)));

    // R8: acknowledged bits with no new completion are clear after the edge.
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |=> ((done_q & $past(ack_mask & ~retire_vec)) == '0));

    // R6: stray bits never enter done on their own.
    a_r6_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_vld && !ack_vld) |=>
            ((done_q & ~$past(done_q)) == ($past(pkt_mask) & $past(pend_q) & ~$past(done_q))));

endmodule

// File: rtl/cq_irq_merge.sv
// Module: cq_irq_merge
// Drives the level-sensitive interrupt from the done vector. Completions
// that arrive while the line is high merge into it without a new edge.
// Assumes: done_q is a registered vector, so irq is glitch-free per cycle.
module cq_irq_merge #(
    parameter int unsigned TAGS = 32
) (
    input  logic [TAGS-1:0] done_q,
    input  logic            irq_en,
    output logic            irq
);

    // Interrupt request: enabled and anything awaiting service.
    always_comb irq = irq_en && (done_q != '0);

endmodule

// File: rtl/cq_tracker_top.sv
// Module: cq_tracker_top
// Tracks queued commands by tag, takes multi-tag status packets with no
// handshake, keeps a write-one-to-clear done vector, a sticky protocol
// error flag and one merged level interrupt.
// Assumes: synchronous active-low reset held for at least one edge.
module cq_tracker_top #(
    parameter int unsigned TAGS  = cq_pkg::CQ_DEF_TAGS,
    parameter int unsigned TAG_W = $clog2(TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [TAG_W-1:0] issue_tag,
    input  logic             pkt_vld,
    input  logic [TAGS-1:0]  pkt_mask,
    input  logic             ack_vld,
    input  logic [TAGS-1:0]  ack_mask,
    input  logic             irq_en,
    output logic [TAGS-1:0]  pend_vec,
    output logic [TAGS-1:0]  done_vec,
    output logic             proto_err,
    output logic             irq
);

    import cq_pkg::*;

    logic [TAGS-1:0] retire_vec;
    logic            stray_any;
    logic            dup_issue;
    cq_fault_t       fault;
    logic            err_q;

    cq_outstanding #(.TAGS(TAGS), .TAG_W(TAG_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_vld  (issue_vld),
        .issue_tag  (issue_tag),
        .retire_vec (retire_vec),
        .pend_q     (pend_vec),
        .dup_issue  (dup_issue)
    );

    cq_done_collector #(.TAGS(TAGS)) u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_vld    (pkt_vld),
        .pkt_mask   (pkt_mask),
        .pend_q     (pend_vec),
        .ack_vld    (ack_vld),
        .ack_mask   (ack_mask),
        .retire_vec (retire_vec),
        .stray_any  (stray_any),
        .done_q     (done_vec)
    );

    cq_irq_merge #(.TAGS(TAGS)) u_irq (
        .done_q (done_vec),
        .irq_en (irq_en),
        .irq    (irq)
    );

    // Gather this cycle's faults.
    always_comb fault = '{dup_issue: dup_issue, stray_done: stray_any};

    // Sticky error flag: set by any fault, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (fault != '0)
            err_q <= 1'b1;
    end

    always_comb proto_err = err_q;

    // R3: a duplicate issue raises the error flag.
    a_r3_dup_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && pend_vec[issue_tag]) |=> proto_err);

    // R6: a stray completion raises the error flag.
    a_r6_stray_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_vld && ((pkt_mask & ~pend_vec) != '0)) |=> proto_err);

    // R7: the error flag never clears outside reset.
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R10: the interrupt only stands when something is done.
    a_r10_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_vec != '0));

    // R11: without an acknowledge, a raised interrupt stays up while enabled.
    a_r11_irq_merged: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_vld) |=> (irq || !irq_en));

    // R4: a tag is never outstanding and done-by-new-completion at once.
    a_r4_moves_once: assert property (@(posedge clk) disable iff (!rst_n)
        (|retire_vec) |=> ((pend_vec & done_vec & $past(retire_vec)) == '0));

endmodule

// File: tb/cq_tracker_top_tb_top.sv
// Scoreboard bench: the driver computes the expected state from the
// requirements and queues it; the monitor compares after each rising edge.
module cq_tracker_top_tb_top;

    localparam int TAGS      = 32;
    localparam int TAG_W     = 5;
    localparam int CLK_PER   = 10;
    localparam int WDOG_CYC  = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue_vld = 1'b0;
    logic [TAG_W-1:0] issue_tag = '0;
    logic             pkt_vld = 1'b0;
    logic [TAGS-1:0]  pkt_mask = '0;
    logic             ack_vld = 1'b0;
    logic [TAGS-1:0]  ack_mask = '0;
    logic             irq_en = 1'b0;
    logic [TAGS-1:0]  pend_vec;
    logic [TAGS-1:0]  done_vec;
    logic             proto_err;
    logic             irq;

    cq_tracker_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_vld (issue_vld),
        .issue_tag (issue_tag),
        .pkt_vld   (pkt_vld),
        .pkt_mask  (pkt_mask),
        .ack_vld   (ack_vld),
        .ack_mask  (ack_mask),
        .irq_en    (irq_en),
        .pend_vec  (pend_vec),
        .done_vec  (done_vec),
        .proto_err (proto_err),
        .irq       (irq)
    );

    always #(CLK_PER/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state built from the requirements.
    logic [TAGS-1:0] m_pend = '0;
    logic [TAGS-1:0] m_done = '0;
    logic            m_err  = 1'b0;
    logic            m_ien  = 1'b0;

    logic [TAGS-1:0] q_pend[$];
    logic [TAGS-1:0] q_done[$];
    logic            q_err[$];
    logic            q_irq[$];
    string           q_req[$];

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus plus its expected result.
    task automatic step(input logic iv, input logic [TAG_W-1:0] it,
                        input logic pv, input logic [TAGS-1:0] pm,
                        input logic av, input logic [TAGS-1:0] am,
                        input logic ien, input string req);
        logic [TAGS-1:0] good;
        logic [TAGS-1:0] stray;
        logic            dup;
        @(negedge clk);
        issue_vld = iv; issue_tag = it;
        pkt_vld = pv;   pkt_mask = pm;
        ack_vld = av;   ack_mask = am;
        irq_en = ien;   m_ien = ien;
        good  = pv ? (pm & m_pend) : '0;
        stray = pv ? (pm & ~m_pend) : '0;
        dup   = iv && m_pend[it];
        m_done = (m_done & ~(av ? am : '0)) | good;
        m_pend = m_pend & ~good;
        if (iv && !dup) m_pend[it] = 1'b1;
        m_err = m_err | dup | (stray != '0);
        q_pend.push_back(m_pend);
        q_done.push_back(m_done);
        q_err.push_back(m_err);
        q_irq.push_back(m_ien && (m_done != '0));
        q_req.push_back(req);
    endtask

    task automatic idle(input logic ien, input string req);
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, ien, req);
    endtask

    task automatic issue(input int t, input logic ien, input string req);
        step(1'b1, TAG_W'(t), 1'b0, '0, 1'b0, '0, ien, req);
    endtask

    // Monitor: compare each result one edge after its stimulus.
    always @(posedge clk) begin
        #1;
        if (rst_n && q_req.size() > 0) begin
            logic [TAGS-1:0] ep, ed;
            logic ee, ei;
            string r;
            ep = q_pend.pop_front(); ed = q_done.pop_front();
            ee = q_err.pop_front();  ei = q_irq.pop_front();
            r  = q_req.pop_front();
            checks++;
            if (pend_vec !== ep) begin
                errors++;
                $display("FAIL %s pend_vec act=%h exp=%h", r, pend_vec, ep);
            end
            if (done_vec !== ed) begin
                errors++;
                $display("FAIL %s done_vec act=%h exp=%h", r, done_vec, ed);
            end
            if (proto_err !== ee) begin
                errors++;
                $display("FAIL %s proto_err act=%b exp=%b", r, proto_err, ee);
            end
            if (irq !== ei) begin
                errors++;
                $display("FAIL %s irq act=%b exp=%b", r, irq, ei);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        idle(1'b1, "R1");
        // R2: issue several tags, including the extremes.
        issue(0, 1'b1, "R2");
        issue(5, 1'b1, "R2");
        issue(31, 1'b1, "R2");
        issue(17, 1'b1, "R2");
        // R4: one packet retires several tags; R10 raises irq.
        step(1'b0, '0, 1'b1, 32'h8000_0021, 1'b0, '0, 1'b1, "R4_R10");
        // R8: acknowledge part of done.
        step(1'b0, '0, 1'b0, '0, 1'b1, 32'h0000_0020, 1'b1, "R8");
        // R11: new completion while irq high merges.
        step(1'b0, '0, 1'b1, 32'h0002_0000, 1'b0, '0, 1'b1, "R11");
        // R10: enable low masks irq, high restores it.
        idle(1'b0, "R10");
        idle(1'b1, "R10");
        // R8: clear everything, irq falls.
        step(1'b0, '0, 1'b0, '0, 1'b1, 32'hFFFF_FFFF, 1'b1, "R8_R10");
        // R5: back-to-back packets.
        for (int t = 1; t <= 4; t++) issue(t, 1'b1, "R2");
        step(1'b0, '0, 1'b1, 32'h0000_0002, 1'b0, '0, 1'b1, "R5");
        step(1'b0, '0, 1'b1, 32'h0000_0004, 1'b0, '0, 1'b1, "R5");
        step(1'b0, '0, 1'b1, 32'h0000_0018, 1'b0, '0, 1'b1, "R5");
        // R9: clear and new completion of the same tag together.
        issue(3, 1'b1, "R2");
        step(1'b0, '0, 1'b1, 32'h0000_0008, 1'b1, 32'h0000_001E, 1'b1, "R9");
        step(1'b0, '0, 1'b0, '0, 1'b1, 32'hFFFF_FFFF, 1'b1, "R8");
        // R6: stray completion is ignored; error set; R7 sticky.
        issue(9, 1'b1, "R2");
        step(1'b0, '0, 1'b1, 32'h0000_0400, 1'b0, '0, 1'b1, "R6");
        idle(1'b1, "R7");
        idle(1'b1, "R7");
        // R3: duplicate issue after a reset.
        @(negedge clk); rst_n = 1'b0;
        q_pend.delete(); q_done.delete(); q_err.delete(); q_irq.delete(); q_req.delete();
        m_pend = '0; m_done = '0; m_err = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle(1'b1, "R1");
        issue(12, 1'b1, "R2");
        issue(12, 1'b1, "R3");
        idle(1'b1, "R7");
        // R12: issue and completion of the same tag in one cycle, after reset.
        @(negedge clk); rst_n = 1'b0;
        q_pend.delete(); q_done.delete(); q_err.delete(); q_irq.delete(); q_req.delete();
        m_pend = '0; m_done = '0; m_err = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 5'd7, 1'b1, 32'h0000_0080, 1'b0, '0, 1'b1, "R12");
        step(1'b0, '0, 1'b1, 32'h0000_0080, 1'b0, '0, 1'b1, "R4");
        idle(1'b1, "R10");
        repeat (3) @(negedge clk);
        report();
    end

endmodule